// File: doc/BRIEF.md
# Snooping MSI Cache-Line Coherence Controller

This block holds the coherence state, tag and data of every line in a small direct-mapped write-back cache. The cache sits on a snooping bus together with other caches of the same kind. Each line is in one of three states: Invalid, Shared or Exclusive. Shared means the line is clean, read-only and may also be held elsewhere. Exclusive means this cache holds the only copy, the copy is dirty and it may be written. Processor reads and writes that can be served locally finish in the cycle they are presented. Any other access asks the bus arbiter for the bus, may first write back a dirty victim, and then places a read miss or a write miss on the bus. The line is then filled from the data response.

While the bus belongs to another cache, the controller watches the misses that cache issues. If a miss hits one of its own lines, it gives up or downgrades that line. If the line is dirty, it also supplies the line's data on a flush path, and that data replaces the memory's reply. No line state changes for a processor request until the bus is won. The miss or write-back decision is made only at grant time, so a snoop that hits the pending line while the controller waits is handled first and the request restarts from the updated state.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset, bus_req, flush_valid and cpu_ready are low, bus_cmd_out is 00, and every line is Invalid, so the first access to any address misses.
- R2: A read to a line that is not present places a read miss on the bus. Bus commands are 2 bits: 00 idle, 01 read miss, 10 write miss, 11 write-back. The line is filled from fill_data and becomes Shared. cpu_ready rises 6 cycles after the request when no write-back is needed.
- R3: A write to a line that is Invalid, Shared or holds another tag places a write miss (10). After the fill, the line is Exclusive and holds the write data.
- R4: A read that matches a Shared or Exclusive line, or a write that matches an Exclusive line, raises cpu_ready in the same cycle with no bus command. Read data comes from the line.
- R5: A miss whose index holds an Exclusive line with a different tag first issues a write-back (11) carrying the victim's address and data, then the miss in the next cycle. A Shared victim is dropped without a bus command.
- R6: A snooped read miss that matches an Exclusive line raises flush_valid one cycle later with the line data, and the line becomes Shared.
- R7: A snooped write miss that matches a Shared line makes it Invalid. A matching Exclusive line is first flushed one cycle later and then becomes Invalid.
- R8: A command is driven only while bus_gnt is high. The choice between write-back and miss is made when the grant arrives, so a snoop that hits the pending line while the controller waits changes what the controller issues.
- R9: cpu_ready stays low while a miss is outstanding. bus_req stays high from the request until the fill is taken, and after a miss command no further command follows until the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | AW | Word address; low bits index, high bits tag |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_cmd_out | output | 2 | Command driven while granted |
| bus_addr_out | output | AW | Address of the driven command |
| bus_data_out | output | DW | Write-back data |
| snp_cmd | input | 2 | Command currently on the shared bus |
| snp_addr | input | AW | Address currently on the shared bus |
| fill_valid | input | 1 | Fill data valid for the outstanding miss |
| fill_data | input | DW | Fill data |
| flush_valid | output | 1 | Dirty line supplied in response to a snoop |
| flush_data | output | DW | Data of the flushed line |

## Verification
A local hit raises cpu_ready in the request cycle. A miss is ready on the 6th cycle after the request, or on the 7th when a write-back goes first. The bench counts falling edges from the request and compares with these counts. A miss command is answered by the bench memory two cycles later, and a peer's flush appears one cycle after the command. Every bus command and flush is sampled on the falling edge in the cycle it is driven, so the scoreboard sees the same sequence of transactions whatever the latency between them.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int LINES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd_out,
  output logic [AW-1:0] bus_addr_out,
  output logic [DW-1:0] bus_data_out,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  output logic          flush_valid,
  output logic [DW-1:0] flush_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;
  localparam logic [1:0] CMD_RD = 2'b01, CMD_WR = 2'b10, CMD_WB = 2'b11;

  typedef enum logic [1:0] {INV, SHR, EXC} line_t;
  typedef enum logic [2:0] {IDLE, ARB, WBK, MISS, FILL} fsm_t;

  line_t         st_q  [LINES];
  logic [TW-1:0] tag_q [LINES];
  logic [DW-1:0] dat_q [LINES];
  fsm_t          fsm;

  wire [IW-1:0] c_idx = cpu_addr[IW-1:0];
  wire [TW-1:0] c_tag = cpu_addr[AW-1:IW];
  wire c_match = st_q[c_idx] != INV && tag_q[c_idx] == c_tag;
  wire c_hit   = c_match && (!cpu_we || st_q[c_idx] == EXC);
  wire victim_dirty = st_q[c_idx] == EXC && tag_q[c_idx] != c_tag;

  wire [IW-1:0] s_idx = snp_addr[IW-1:0];
  wire s_miss  = !bus_gnt && (snp_cmd == CMD_RD || snp_cmd == CMD_WR);
  wire s_match = s_miss && st_q[s_idx] != INV && tag_q[s_idx] == snp_addr[AW-1:IW];

  assign cpu_ready = fsm == IDLE && cpu_req && c_hit && !(s_match && s_idx == c_idx);
  assign cpu_rdata = dat_q[c_idx];
  assign bus_req   = fsm != IDLE;

  always_comb begin
    bus_cmd_out  = 2'b00;
    bus_addr_out = cpu_addr;
    bus_data_out = dat_q[c_idx];
    if (fsm == WBK) begin
      bus_cmd_out  = CMD_WB;
      bus_addr_out = {tag_q[c_idx], c_idx};
    end else if (fsm == MISS) begin
      bus_cmd_out = cpu_we ? CMD_WR : CMD_RD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm         <= IDLE;
      flush_valid <= 1'b0;
      flush_data  <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      flush_valid <= 1'b0;
      if (s_match) begin
        if (st_q[s_idx] == EXC) begin
          flush_valid <= 1'b1;
          flush_data  <= dat_q[s_idx];
        end
        if (snp_cmd == CMD_WR) st_q[s_idx] <= INV;
        else if (st_q[s_idx] == EXC) st_q[s_idx] <= SHR;
      end
      case (fsm)
        IDLE: begin
          if (cpu_ready && cpu_we) dat_q[c_idx] <= cpu_wdata;
          else if (cpu_req && !c_hit) fsm <= ARB;
        end
        ARB: if (bus_gnt) fsm <= victim_dirty ? WBK : MISS;
        WBK: begin
          st_q[c_idx] <= INV;
          fsm <= MISS;
        end
        MISS: fsm <= FILL;
        FILL: if (fill_valid) begin
          dat_q[c_idx] <= fill_data;
          tag_q[c_idx] <= c_tag;
          st_q[c_idx]  <= cpu_we ? EXC : SHR;
          fsm <= IDLE;
        end
        default: fsm <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [1:0]    bus_cmd_out,
  input logic [AW-1:0] bus_addr_out,
  input logic [DW-1:0] bus_data_out,
  input logic [1:0]    snp_cmd,
  input logic          fill_valid,
  input logic          flush_valid
);
  wire is_miss = bus_cmd_out == 2'b01 || bus_cmd_out == 2'b10;

  assert_cmd_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_out != 2'b00) |-> bus_gnt);

  assert_ready_not_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req);

  assert_wb_then_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_out == 2'b11) |=> (bus_cmd_out == 2'b01 || bus_cmd_out == 2'b10));

  assert_miss_then_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_miss |=> (bus_req && bus_cmd_out == 2'b00));

  assert_flush_after_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(!bus_gnt && (snp_cmd == 2'b01 || snp_cmd == 2'b10)));

  assert_req_until_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(fill_valid));

  wire unused_ok = ^{bus_addr_out, bus_data_out};
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd_out(bus_cmd_out), .bus_addr_out(bus_addr_out),
  .bus_data_out(bus_data_out), .snp_cmd(snp_cmd), .fill_valid(fill_valid),
  .flush_valid(flush_valid)
);

// File: tb/tb_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_msi_snoop_ctrl;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n;

  logic          c_req [2];
  logic          c_we  [2];
  logic [AW-1:0] c_addr[2];
  logic [DW-1:0] c_wd  [2];
  logic          c_rdy [2];
  logic [DW-1:0] c_rd  [2];
  logic          breq  [2];
  logic          gnt   [2];
  logic [1:0]    ocmd  [2];
  logic [AW-1:0] oaddr [2];
  logic [DW-1:0] odata [2];
  logic          fl_v  [2];
  logic [DW-1:0] fl_d  [2];

  logic [1:0]    own;
  logic [1:0]    bcmd;
  logic [AW-1:0] baddr;
  logic [DW-1:0] bdata;
  logic          fv;
  logic [DW-1:0] fdata;
  logic          s1_v;
  logic [AW-1:0] s1_a;
  logic [DW-1:0] mem [256];

  assign gnt[0] = own == 2'd1;
  assign gnt[1] = own == 2'd2;
  assign bcmd   = ocmd[0] | ocmd[1];
  assign baddr  = gnt[1] ? oaddr[1] : oaddr[0];
  assign bdata  = gnt[1] ? odata[1] : odata[0];

  msi_snoop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[0]), .cpu_we(c_we[0]),
    .cpu_addr(c_addr[0]), .cpu_wdata(c_wd[0]), .cpu_ready(c_rdy[0]),
    .cpu_rdata(c_rd[0]), .bus_req(breq[0]), .bus_gnt(gnt[0]),
    .bus_cmd_out(ocmd[0]), .bus_addr_out(oaddr[0]), .bus_data_out(odata[0]),
    .snp_cmd(bcmd), .snp_addr(baddr), .fill_valid(fv), .fill_data(fdata),
    .flush_valid(fl_v[0]), .flush_data(fl_d[0]));

  msi_snoop_ctrl peer (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[1]), .cpu_we(c_we[1]),
    .cpu_addr(c_addr[1]), .cpu_wdata(c_wd[1]), .cpu_ready(c_rdy[1]),
    .cpu_rdata(c_rd[1]), .bus_req(breq[1]), .bus_gnt(gnt[1]),
    .bus_cmd_out(ocmd[1]), .bus_addr_out(oaddr[1]), .bus_data_out(odata[1]),
    .snp_cmd(bcmd), .snp_addr(baddr), .fill_valid(fv), .fill_data(fdata),
    .flush_valid(fl_v[1]), .flush_data(fl_d[1]));

  always_ff @(posedge clk) begin
    if (!rst_n) own <= 2'd0;
    else if (own == 2'd0) begin
      if (breq[1]) own <= 2'd2;
      else if (breq[0]) own <= 2'd1;
    end else if ((own == 2'd1 && !breq[0]) || (own == 2'd2 && !breq[1])) own <= 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_a <= '0; fv <= 1'b0; fdata <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else begin
      s1_v <= bcmd == 2'b01 || bcmd == 2'b10;
      s1_a <= baddr;
      if (bcmd == 2'b11) mem[baddr] <= bdata;
      fv <= s1_v;
      if (s1_v) begin
        if (fl_v[0]) begin fdata <= fl_d[0]; mem[s1_a] <= fl_d[0]; end
        else if (fl_v[1]) begin fdata <= fl_d[1]; mem[s1_a] <= fl_d[1]; end
        else fdata <= mem[s1_a];
      end
    end
  end

  typedef struct {int kind; int src; logic [AW-1:0] addr; logic [DW-1:0] data;} item_t;
  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int kind);
    case (kind)
      1: return "R2";
      2: return "R3";
      3: return "R5";
      default: return "R6/R7";
    endcase
  endfunction

  task automatic push(int kind, int src, logic [AW-1:0] addr, logic [DW-1:0] data);
    item_t it;
    it.kind = kind; it.src = src; it.addr = addr; it.data = data;
    exp_q.push_back(it);
  endtask

  task automatic compare(item_t got);
    item_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, req_of(got.kind), "unexpected bus item kind", got.kind, 0);
      return;
    end
    e = exp_q.pop_front();
    chk(got.kind == e.kind, req_of(e.kind), "bus item kind", got.kind, e.kind);
    chk(got.src == e.src, req_of(e.kind), "bus item source", got.src, e.src);
    chk(got.addr == e.addr, req_of(e.kind), "bus item address", got.addr, e.addr);
    if (e.kind >= 3) chk(got.data == e.data, req_of(e.kind), "bus item data", got.data, e.data);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bcmd != 2'b00) compare('{int'(bcmd), gnt[1] ? 1 : 0, baddr, bdata});
      for (int i = 0; i < 2; i++)
        if (fl_v[i]) compare('{4, i, s1_a, fl_d[i]});
    end
  end

  task automatic cpu_op(int p, bit we, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic [DW-1:0] exp_rd, int exp_lat, string req);
    int n = 0;
    @(negedge clk);
    c_req[p] = 1'b1; c_we[p] = we; c_addr[p] = a; c_wd[p] = d;
    forever begin
      #1;
      if (c_rdy[p]) break;
      @(negedge clk);
      n++;
      if (n > 200) break;
    end
    if (exp_lat >= 0) chk(n == exp_lat, req, "ready latency", n, exp_lat);
    if (!we) chk(c_rd[p] == exp_rd, req, "read data", c_rd[p], exp_rd);
    @(posedge clk);
    #1 c_req[p] = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      c_req[i] = 1'b0; c_we[i] = 1'b0; c_addr[i] = '0; c_wd[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 2; i++) begin
      chk(!breq[i], "R1", "bus_req after reset", breq[i], 0);
      chk(ocmd[i] == 2'b00 && !fl_v[i] && !c_rdy[i], "R1", "idle outputs after reset",
          {ocmd[i], fl_v[i], c_rdy[i]}, 0);
    end

    // P1 writes 10 to 0x13: write miss, line becomes Exclusive (R3)
    push(2, 0, 8'h13, 0);
    cpu_op(0, 1, 8'h13, 32'd10, 0, 6, "R3");
    chk(mem[8'h13] == 0, "R3", "memory untouched by dirty write", mem[8'h13], 0);

    // P1 reads 0x13: local hit (R4)
    cpu_op(0, 0, 8'h13, 0, 32'd10, 0, "R4");

    // P2 reads 0x13: read miss on Invalid (R1, R2), P1 flushes and downgrades (R6)
    push(1, 1, 8'h13, 0);
    push(4, 0, 8'h13, 32'd10);
    cpu_op(1, 0, 8'h13, 0, 32'd10, 6, "R2");
    chk(mem[8'h13] == 32'd10, "R6", "memory after flush", mem[8'h13], 32'd10);

    // P1 reads again: Shared hit (R4, R6)
    cpu_op(0, 0, 8'h13, 0, 32'd10, 0, "R6");
    cpu_op(1, 0, 8'h13, 0, 32'd10, 0, "R4");

    // P2 writes 20: Shared is a miss; P1 Shared copy dropped silently (R3, R7)
    push(2, 1, 8'h13, 0);
    cpu_op(1, 1, 8'h13, 32'd20, 0, 6, "R3");

    // P1 reads: its line was invalidated, P2 flushes 20 (R7, R6)
    push(1, 0, 8'h13, 0);
    push(4, 1, 8'h13, 32'd20);
    cpu_op(0, 0, 8'h13, 0, 32'd20, 6, "R7");
    chk(mem[8'h13] == 32'd20, "R6", "memory after second flush", mem[8'h13], 32'd20);

    // P2 writes 40 to 0x23: Shared victim dropped, no write-back (R5)
    push(2, 1, 8'h23, 0);
    cpu_op(1, 1, 8'h23, 32'd40, 0, 6, "R5");

    // P2 writes 50 to 0x33: dirty victim 0x23 written back first (R5)
    push(3, 1, 8'h23, 32'd40);
    push(2, 1, 8'h33, 0);
    cpu_op(1, 1, 8'h33, 32'd50, 0, 7, "R5");
    chk(mem[8'h23] == 32'd40, "R5", "victim written back", mem[8'h23], 32'd40);

    // Race: both write 0x13; P2 wins, P1's waiting Shared line is invalidated,
    // P1 restarts as a plain write miss with no write-back (R8)
    push(3, 1, 8'h33, 32'd50);
    push(2, 1, 8'h13, 0);
    push(2, 0, 8'h13, 0);
    push(4, 1, 8'h13, 32'd60);
    fork
      cpu_op(0, 1, 8'h13, 32'd70, 0, -1, "R8");
      cpu_op(1, 1, 8'h13, 32'd60, 0, 7, "R8");
    join
    chk(mem[8'h13] == 32'd60, "R8", "memory holds winner data", mem[8'h13], 32'd60);
    chk(mem[8'h33] == 32'd50, "R5", "second victim written back", mem[8'h33], 32'd50);

    cpu_op(0, 0, 8'h13, 0, 32'd70, 0, "R4");
    push(1, 1, 8'h13, 0);
    push(4, 0, 8'h13, 32'd70);
    cpu_op(1, 0, 8'h13, 0, 32'd70, 6, "R9");
    chk(mem[8'h13] == 32'd70, "R6", "memory after last flush", mem[8'h13], 32'd70);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule